// File: doc/BRIEF.md
# Twelvefold Repetition Time-Division Serializer

This block turns a slow serial bit stream into a synchronous line stream twelve times faster. Each incoming bit fills one frame of twelve consecutive line slots, so the line carries every bit twelve times over. No data is added or altered: the net information rate on the line equals the input rate. For example, a 50 bps source becomes a 600 bps line stream.

The block is built as a time-division selector. The held bit is copied onto twelve inputs of a sixteen-way selector. The remaining four inputs are tied low. A slot address steps through the twelve used inputs in order. The downstream modem is the timing master: the block moves forward only on the line clock-enable it receives and never makes a rate of its own. At each frame wrap the block latches the next source bit and raises a one-cycle request, so the source can present the bit after that.

Top module: `rep12_tdm_serializer`

## Requirements
- R1: During every slot of a frame, `line_out` equals the bit latched for that frame. Each latched bit therefore appears in exactly twelve consecutive slots.
- R2: The slot address advances by one slot per `SLOT_TICKS` pulses of `line_ce` (default 1). While `line_ce` is low, `line_out`, `frame_start` and the address hold their values.
- R3: The slot address counts 0, 1, …, 11 and then returns to 0. It never takes the values 12 to 15. A frame is therefore twelve slots long.
- R4: `src_bit` is sampled only at the wrap edge, which is the clock edge that ends slot 11. Changes to `src_bit` at any other time have no effect on `line_out`.
- R5: `bit_req` is high for exactly one clock cycle: the cycle after each wrap edge. It is low at all other times.
- R6: `frame_start` is high exactly while slot 0 is being sent. It is therefore high in the cycle after each wrap edge and low in slots 1 to 11.
- R7: The synchronous active-high `rst` has priority over `line_ce`. In the cycle after a reset edge, the address is 0, the held bit is 0, `line_out` is 0, `frame_start` is 1 and `bit_req` is 0.
- R8: Selector inputs 0 to 11 all carry the held bit. Inputs 12 to 15 are tied to 0, so the selector output always matches the held bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| line_ce | input | 1 | Line clock-enable from the modem, one pulse per line bit period |
| src_bit | input | 1 | Low-rate source data bit |
| bit_req | output | 1 | One-cycle request for the next source bit |
| line_out | output | 1 | Serial line output |
| frame_start | output | 1 | High while slot 0 of a frame is on the line |

## Verification
A slot address that skips a value or strays above 11 changes the frame length. This shows within one frame as a misplaced `frame_start` or an early `bit_req`. A held bit that is reloaded at the wrong edge shows as a value change on `line_out` inside a frame, at the first slot after the bad load. A selector that reads an unused or wrong input shows as a wrong `line_out` level in that same slot. The bench compares `line_out` against the expected bit in every slot, so each of these faults is caught in the slot where it first appears.

// File: rtl/rep12_pkg.sv
package rep12_pkg;

  // Next slot index in a frame of 'slots' slots.
  function automatic int next_slot(int cur, int slots);
    return (cur >= slots - 1) ? 0 : cur + 1;
  endfunction

  // True when 'cur' is the final slot of the frame.
  function automatic bit is_last_slot(int cur, int slots);
    return cur == slots - 1;
  endfunction

  // Width of an index that covers 'n' values (at least one bit).
  function automatic int idx_width(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/rep12_slot_seq.sv
module rep12_slot_seq #(
  parameter int SLOTS      = 12,
  parameter int SLOT_TICKS = 1,
  parameter int ADDR_W     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_ce,
  output logic [ADDR_W-1:0] addr,
  output logic              slot_end,
  output logic              wrap
);

  localparam int TICK_W = rep12_pkg::idx_width(SLOT_TICKS);

  generate
    if (SLOT_TICKS == 1) begin : g_single_tick
      assign slot_end = line_ce;
    end else begin : g_multi_tick
      logic [TICK_W-1:0] tick;
      always_ff @(posedge clk) begin
        if (rst) begin
          tick <= '0;
        end else if (line_ce) begin
          tick <= (tick == TICK_W'(SLOT_TICKS - 1)) ? '0 : tick + 1'b1;
        end
      end
      assign slot_end = line_ce && (tick == TICK_W'(SLOT_TICKS - 1));
    end
  endgenerate

  assign wrap = slot_end && rep12_pkg::is_last_slot(int'(addr), SLOTS);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
    end else if (slot_end) begin
      addr <= ADDR_W'(rep12_pkg::next_slot(int'(addr), SLOTS));
    end
  end

endmodule

// File: rtl/rep12_fanout.sv
module rep12_fanout #(
  parameter int SLOTS    = 12,
  parameter int SEL_WAYS = 16
) (
  input  logic                bit_in,
  output logic [SEL_WAYS-1:0] fan
);

  generate
    for (genvar g = 0; g < SEL_WAYS; g++) begin : g_leg
      if (g < SLOTS) begin : g_used
        assign fan[g] = bit_in;
      end else begin : g_spare
        assign fan[g] = 1'b0;
      end
    end
  endgenerate

endmodule

// File: rtl/rep12_sel.sv
module rep12_sel #(
  parameter int SEL_WAYS = 16,
  parameter int ADDR_W   = 4
) (
  input  logic [SEL_WAYS-1:0] ins,
  input  logic [ADDR_W-1:0]   addr,
  output logic                y
);

  assign y = ins[addr];

endmodule

// File: rtl/rep12_tdm_serializer.sv
module rep12_tdm_serializer #(
  parameter int SLOTS      = 12,
  parameter int SEL_WAYS   = 16,
  parameter int SLOT_TICKS = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic line_ce,
  input  logic src_bit,
  output logic bit_req,
  output logic line_out,
  output logic frame_start
);

  localparam int ADDR_W = rep12_pkg::idx_width(SEL_WAYS);

  // Internal events, named for the checker.
  logic [ADDR_W-1:0]   addr;
  logic                slot_end;
  logic                wrap;
  logic                held;
  logic [SEL_WAYS-1:0] fan;
  logic                sel_y;

  rep12_slot_seq #(
    .SLOTS(SLOTS), .SLOT_TICKS(SLOT_TICKS), .ADDR_W(ADDR_W)
  ) i_seq (
    .clk(clk), .rst(rst), .line_ce(line_ce),
    .addr(addr), .slot_end(slot_end), .wrap(wrap)
  );

  // The source bit is taken in only at the frame wrap.
  always_ff @(posedge clk) begin
    if (rst) begin
      held    <= 1'b0;
      bit_req <= 1'b0;
    end else begin
      if (wrap) held <= src_bit;
      bit_req <= wrap;
    end
  end

  rep12_fanout #(.SLOTS(SLOTS), .SEL_WAYS(SEL_WAYS)) i_fan (
    .bit_in(held), .fan(fan)
  );

  rep12_sel #(.SEL_WAYS(SEL_WAYS), .ADDR_W(ADDR_W)) i_sel (
    .ins(fan), .addr(addr), .y(sel_y)
  );

  assign line_out    = sel_y;
  assign frame_start = (addr == '0);

endmodule

// File: rtl/rep12_tdm_checker.sv
module rep12_tdm_checker #(
  parameter int SLOTS  = 12,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              line_ce,
  input logic [ADDR_W-1:0] addr,
  input logic              wrap,
  input logic              held,
  input logic              bit_req,
  input logic              line_out,
  input logic              frame_start
);

  a_r3_addr_range: assert property (@(posedge clk) disable iff (rst)
    addr < ADDR_W'(SLOTS))
    else $error("a_r3_addr_range");

  a_r2_hold_no_ce: assert property (@(posedge clk) disable iff (rst)
    !line_ce |=> $stable(addr))
    else $error("a_r2_hold_no_ce");

  a_r4_held_only_at_wrap: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(held))
    else $error("a_r4_held_only_at_wrap");

  a_r5_req_after_wrap: assert property (@(posedge clk) disable iff (rst)
    wrap |=> bit_req)
    else $error("a_r5_req_after_wrap");

  a_r5_req_one_cycle: assert property (@(posedge clk) disable iff (rst)
    bit_req |=> !bit_req)
    else $error("a_r5_req_one_cycle");

  a_r6_frame_after_wrap: assert property (@(posedge clk) disable iff (rst)
    wrap |=> frame_start)
    else $error("a_r6_frame_after_wrap");

  a_r8_line_is_held: assert property (@(posedge clk) disable iff (rst)
    line_out == held)
    else $error("a_r8_line_is_held");

  a_r7_reset_state: assert property (@(posedge clk)
    rst |=> (addr == '0 && !held && !bit_req && !line_out))
    else $error("a_r7_reset_state");

endmodule

bind rep12_tdm_serializer rep12_tdm_checker #(
  .SLOTS(SLOTS), .ADDR_W(ADDR_W)
) i_chk (
  .clk(clk), .rst(rst), .line_ce(line_ce), .addr(addr), .wrap(wrap),
  .held(held), .bit_req(bit_req), .line_out(line_out),
  .frame_start(frame_start)
);

// File: tb/test_rep12_tdm_serializer.sv
module test_rep12_tdm_serializer;

  localparam int FRAME = 12;
  // Vector: [3] = source bit for the frame, [2:0] = idle cycles between line_ce pulses.
  localparam int NV = 10;
  localparam logic [3:0] VEC [NV] = '{
    4'b1_000, 4'b0_001, 4'b1_011, 4'b1_000, 4'b0_111,
    4'b0_010, 4'b1_001, 4'b0_000, 4'b1_101, 4'b1_000
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_ce = 1'b0;
  logic src_bit = 1'b0;
  logic bit_req, line_out, frame_start;
  int checks = 0;
  int fails = 0;
  logic prev;

  always #2.5 clk = ~clk;

  rep12_tdm_serializer i_rep12_tdm_serializer (
    .clk(clk), .rst(rst), .line_ce(line_ce), .src_bit(src_bit),
    .bit_req(bit_req), .line_out(line_out), .frame_start(frame_start)
  );

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // One line_ce pulse, then sample at the following falling edge.
  task automatic pulse();
    line_ce = 1'b1;
    @(posedge clk);
    @(negedge clk);
    line_ce = 1'b0;
  endtask

  // Sends one frame that should carry 'exp'; offers 'nxt' for latching at the wrap.
  task automatic run_frame(logic exp, logic nxt, int gap);
    src_bit = nxt;
    for (int s = 0; s < FRAME; s++) begin
      if (s == 3) src_bit = ~nxt;   // R4: mid-frame change must be ignored
      if (s == 9) src_bit = nxt;
      check($sformatf("R1/R4 slot %0d line_out", s), line_out, exp);
      check($sformatf("R6 slot %0d frame_start", s), frame_start, s == 0);
      pulse();
      check($sformatf("R5 bit_req after slot %0d", s), bit_req, s == FRAME - 1);
      if (gap > 0) begin
        repeat (gap) @(negedge clk);
        if (s != FRAME - 1) begin
          check("R2 line_out held while idle", line_out, exp);
          check("R2 frame_start held while idle", frame_start, 1'b0);
        end
        check("R5 bit_req single cycle", bit_req, 1'b0);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R7 reset line_out", line_out, 1'b0);
    check("R7 reset frame_start", frame_start, 1'b1);
    check("R7 reset bit_req", bit_req, 1'b0);
    rst = 1'b0;
    @(negedge clk);

    // Table walk: frame k carries the bit latched at the end of frame k-1.
    prev = 1'b0;
    for (int k = 0; k < NV; k++) begin
      run_frame(prev, VEC[k][3], int'(VEC[k][2:0]));
      prev = VEC[k][3];
    end
    run_frame(prev, 1'b1, 0);

    // R2: a long stall mid-frame keeps everything in place (held bit is 1).
    for (int s = 0; s < 4; s++) pulse();
    repeat (30) @(negedge clk);
    check("R2 long stall line_out", line_out, 1'b1);
    check("R2 long stall frame_start", frame_start, 1'b0);
    check("R2 long stall bit_req", bit_req, 1'b0);
    // R3: after the stall, eight more slots end the frame (4 + 8 = 12).
    for (int s = 4; s < FRAME; s++) begin
      check("R3 frame_start low before wrap", frame_start, 1'b0);
      pulse();
    end
    check("R3 wrap after exactly twelve slots", frame_start, 1'b1);
    check("R3 bit_req at wrap", bit_req, 1'b1);

    // R7: reset mid-frame with line_ce high; the held bit (1) must clear.
    for (int s = 0; s < 5; s++) pulse();
    check("R7 pre-reset line_out", line_out, 1'b1);
    rst = 1'b1;
    line_ce = 1'b1;
    @(posedge clk);
    @(negedge clk);
    line_ce = 1'b0;
    rst = 1'b0;
    check("R7 mid-frame reset line_out", line_out, 1'b0);
    check("R7 mid-frame reset frame_start", frame_start, 1'b1);
    check("R7 mid-frame reset bit_req", bit_req, 1'b0);
    run_frame(1'b0, 1'b1, 0);
    run_frame(1'b1, 1'b0, 1);

    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

endmodule